// File: doc/BRIEF.md
# L1 Test-Command Indirect Access Engine

This block gives software a way to reach level-one memory indirectly, one 64-bit word at a time. Software loads a 32-bit test command. The engine checks it, builds an L1 byte address from selected command bits and a base address, and moves eight bytes between memory and a pair of 32-bit test data words. The transfer runs over a single request/acknowledge memory port.

The command encodes the way, the instruction/data space, the data bank, the sub-bank and the line offset. Each of these fields lands on a fixed L1 address bit, and the result is ORed with the base. Only the data array can be reached. A command that selects the tag array, or that sets a bit with no defined meaning, raises an error flag and never touches memory.

While a transfer is outstanding the engine reports busy. During that time it ignores both command writes and data-word writes.

Top module: `l1_test_xfer`

## Requirements
- R1: After reset the stored command, both data words, busy, mem_req and both error flags are all zero.
- R2: An accepted command starts a transfer only if it is legal. It is legal when it is nonzero, has bit 2 set (bit 2 = 1 selects the data array) and has no bit set in 0xFA7CB801. mem_addr is then formed as: base ORed with command bit 26 at address bit 11, bit 24 at bit 21, bit 23 at bit 15, bits 17:16 at bits 13:12, and bits 14 and 10:3 at their own positions. All other address bits come from the base alone.
- R3: When command bit 1 is 1, the transfer is a write. mem_we is 1 and mem_wdata is {data word 1, data word 0}. Both data words stay unchanged after the acknowledge.
- R4: When command bit 1 is 0, the transfer is a read. In the cycle after mem_ack, data word 0 holds mem_rdata[31:0] and data word 1 holds mem_rdata[63:32].
- R5: A nonzero command with any bit of 0xFA7CB801 set sets err_undef and does not start a transfer.
- R6: A nonzero command with bit 2 clear (tag-array select) sets err_tag and does not start a transfer.
- R7: Each nonzero command accepted while idle rewrites both error flags. Each flag is 1 if its condition holds and 0 otherwise.
- R8: A command write of zero only stores the value. It starts nothing and leaves both error flags unchanged.
- R9: busy and mem_req go high in the cycle after a legal command and stay high, with mem_addr and mem_we stable, until the cycle after mem_ack.
- R10: While busy, command writes and data-word writes are ignored. The stored command and the data words keep their values.
- R11: While idle, a data-word write updates the selected word, and cmd_rd returns the last command accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sram_base | input | 32 | L1 base address ORed into every formed address |
| cmd_we | input | 1 | Command write strobe |
| cmd_wdata | input | 32 | Command value |
| dat_we | input | 2 | Per-word write strobes for data words 1 and 0 |
| dat_wdata | input | 32 | Data-word write value |
| cmd_rd | output | 32 | Stored command |
| dat0_rd | output | 32 | Data word 0 (low half of the 64-bit word) |
| dat1_rd | output | 32 | Data word 1 (high half) |
| busy | output | 1 | Transfer outstanding |
| err_undef | output | 1 | Last nonzero command had undefined bits |
| err_tag | output | 1 | Last nonzero command selected the tag array |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | 1 = write to memory, 0 = read |
| mem_addr | output | 32 | Formed L1 byte address |
| mem_wdata | output | 64 | Data to memory |
| mem_ack | input | 1 | Memory acknowledge |
| mem_rdata | input | 64 | Data from memory, valid with mem_ack |

## Verification
The assertions watch the handshake on every cycle. They check that an illegal or zero command never raises busy, that the request fields hold steady until the acknowledge, that busy drops right after it, and that the stored command stays frozen while busy. The bench alone can show the correctness of the formed address, the routing of each command bit and of read data into the correct halves, and the unchanged data words after writes and ignored updates. To do so it sweeps every single command bit, a walk of legal multi-bit commands over two base values, and several acknowledge latencies.

// File: rtl/l1_test_xfer.sv
module l1_test_xfer #(
  parameter logic [31:0] UNDEF_MASK = 32'hFA7CB801,
  parameter int          ARRAY_BIT  = 2,
  parameter int          WRITE_BIT  = 1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] sram_base,
  input  logic        cmd_we,
  input  logic [31:0] cmd_wdata,
  input  logic [1:0]  dat_we,
  input  logic [31:0] dat_wdata,
  output logic [31:0] cmd_rd,
  output logic [31:0] dat0_rd,
  output logic [31:0] dat1_rd,
  output logic        busy,
  output logic        err_undef,
  output logic        err_tag,
  output logic        mem_req,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [63:0] mem_wdata,
  input  logic        mem_ack,
  input  logic [63:0] mem_rdata
);

  localparam logic [31:0] PASS_MASK = 32'h0000_47F8;

  logic [31:0] cmd_q, lo_q, hi_q, addr_q;
  logic        busy_q, we_q, undef_q, tag_q;

  wire accept   = cmd_we & ~busy_q;
  wire nonzero  = |cmd_wdata;
  wire bad_bits = |(cmd_wdata & UNDEF_MASK);
  wire tag_sel  = ~cmd_wdata[ARRAY_BIT];
  wire start    = accept & nonzero & ~bad_bits & ~tag_sel;
  wire finish   = busy_q & mem_ack;

  logic [31:0] formed;
  always_comb begin
    formed          = sram_base | (cmd_wdata & PASS_MASK);
    formed[11]      = formed[11] | cmd_wdata[26];
    formed[21]      = formed[21] | cmd_wdata[24];
    formed[15]      = formed[15] | cmd_wdata[23];
    formed[13:12]   = formed[13:12] | cmd_wdata[17:16];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q   <= '0;
      busy_q  <= 1'b0;
      we_q    <= 1'b0;
      addr_q  <= '0;
      undef_q <= 1'b0;
      tag_q   <= 1'b0;
    end else begin
      if (accept) cmd_q <= cmd_wdata;
      if (accept && nonzero) begin
        undef_q <= bad_bits;
        tag_q   <= tag_sel;
      end
      if (start) begin
        busy_q <= 1'b1;
        addr_q <= formed;
        we_q   <= cmd_wdata[WRITE_BIT];
      end else if (finish) begin
        busy_q <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q <= '0;
      hi_q <= '0;
    end else if (finish) begin
      if (!we_q) begin
        lo_q <= mem_rdata[31:0];
        hi_q <= mem_rdata[63:32];
      end
    end else if (!busy_q) begin
      if (dat_we[0]) lo_q <= dat_wdata;
      if (dat_we[1]) hi_q <= dat_wdata;
    end
  end

  assign cmd_rd    = cmd_q;
  assign dat0_rd   = lo_q;
  assign dat1_rd   = hi_q;
  assign busy      = busy_q;
  assign mem_req   = busy_q;
  assign mem_we    = we_q;
  assign mem_addr  = addr_q;
  assign mem_wdata = {hi_q, lo_q};
  assign err_undef = undef_q;
  assign err_tag   = tag_q;

endmodule

// File: rtl/l1_test_xfer_chk.sv
module l1_test_xfer_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cmd_we,
  input logic [31:0] cmd_wdata,
  input logic [31:0] cmd_rd,
  input logic        busy,
  input logic        err_undef,
  input logic        err_tag,
  input logic        mem_req,
  input logic        mem_we,
  input logic [31:0] mem_addr,
  input logic        mem_ack
);

  AST_UNDEF_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && cmd_we && |(cmd_wdata & 32'hFA7CB801)) |=> (!busy && err_undef)); // R5

  AST_TAG_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && cmd_we && cmd_wdata != 32'd0 && !cmd_wdata[2]) |=> (!busy && err_tag)); // R6

  AST_ZERO_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && cmd_we && cmd_wdata == 32'd0) |=> (!busy && $stable(err_undef) && $stable(err_tag))); // R8

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && busy && $stable(mem_addr) && $stable(mem_we))); // R9

  AST_ACK_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && mem_ack) |=> !busy); // R9

  AST_BUSY_FREEZES_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cmd_we) |=> $stable(cmd_rd)); // R10

endmodule

bind l1_test_xfer l1_test_xfer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_wdata(cmd_wdata),
  .cmd_rd(cmd_rd), .busy(busy), .err_undef(err_undef), .err_tag(err_tag),
  .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_ack(mem_ack)
);

// File: tb/test_l1_test_xfer.sv
`timescale 1ns/1ps
module test_l1_test_xfer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] sram_base = 32'hFF80_0000;
  logic        cmd_we = 1'b0;
  logic [31:0] cmd_wdata = '0;
  logic [1:0]  dat_we = '0;
  logic [31:0] dat_wdata = '0;
  logic [31:0] cmd_rd, dat0_rd, dat1_rd, mem_addr;
  logic        busy, err_undef, err_tag, mem_req, mem_we;
  logic [63:0] mem_wdata;
  logic        mem_ack = 1'b0;
  logic [63:0] mem_rdata = '0;

  int checks = 0;
  int fails = 0;
  int cyc = 0;

  always #10 clk = ~clk;

  l1_test_xfer i_l1_test_xfer (
    .clk(clk), .rst_n(rst_n), .sram_base(sram_base), .cmd_we(cmd_we),
    .cmd_wdata(cmd_wdata), .dat_we(dat_we), .dat_wdata(dat_wdata),
    .cmd_rd(cmd_rd), .dat0_rd(dat0_rd), .dat1_rd(dat1_rd), .busy(busy),
    .err_undef(err_undef), .err_tag(err_tag), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_addr(input logic [31:0] base, input logic [31:0] c);
    logic [31:0] a = base;
    for (int i = 0; i < 32; i++) begin
      if (c[i]) begin
        case (i)
          26: a[11] = 1'b1;
          24: a[21] = 1'b1;
          23: a[15] = 1'b1;
          16: a[12] = 1'b1;
          17: a[13] = 1'b1;
          14, 3, 4, 5, 6, 7, 8, 9, 10: a[i] = 1'b1;
          default: ;
        endcase
      end
    end
    return a;
  endfunction

  task automatic set_data(input logic [31:0] w0, input logic [31:0] w1);
    @(negedge clk);
    dat_we = 2'b01; dat_wdata = w0;
    @(negedge clk);
    dat_we = 2'b10; dat_wdata = w1;
    @(negedge clk);
    dat_we = 2'b00;
    chk("R11 data word 0", {32'd0, dat0_rd}, {32'd0, w0});
    chk("R11 data word 1", {32'd0, dat1_rd}, {32'd0, w1});
  endtask

  task automatic run_cmd(input logic [31:0] c, input int lat);
    logic undef, tag, legal, pu, pt;
    logic [31:0] w0, w1, ea;
    logic [63:0] rd;
    undef = |(c & 32'hFA7CB801);
    tag   = (c != 0) && !c[2];
    legal = (c != 0) && !undef && !tag;
    pu = err_undef; pt = err_tag;
    w0 = dat0_rd; w1 = dat1_rd;
    ea = exp_addr(sram_base, c);
    @(negedge clk);
    cmd_we = 1'b1; cmd_wdata = c;
    @(negedge clk);
    cmd_we = 1'b0;
    chk("R11 command stored", {32'd0, cmd_rd}, {32'd0, c});
    if (c == 0) begin
      chk("R8 zero starts nothing", {62'd0, busy, mem_req}, 64'd0);
      chk("R8 zero keeps flags", {62'd0, err_undef, err_tag}, {62'd0, pu, pt});
      return;
    end
    chk("R5 R6 R7 flags", {62'd0, err_undef, err_tag}, {62'd0, undef, tag});
    if (!legal) begin
      chk(undef ? "R5 no transfer" : "R6 no transfer", {62'd0, busy, mem_req}, 64'd0);
      return;
    end
    chk("R9 busy and request raised", {62'd0, busy, mem_req}, 64'd3);
    chk("R2 formed address", {32'd0, mem_addr}, {32'd0, ea});
    chk("R3 R4 direction", {63'd0, mem_we}, {63'd0, c[1]});
    if (c[1]) chk("R3 write data", mem_wdata, {w1, w0});
    for (int k = 0; k < lat; k++) begin
      cmd_we = 1'b1; cmd_wdata = ~c;
      dat_we = 2'b11; dat_wdata = 32'hDEAD_0000 | k;
      @(negedge clk);
      cmd_we = 1'b0; dat_we = 2'b00;
      chk("R9 request held", {31'd0, busy, mem_addr}, {31'd0, 1'b1, ea});
      chk("R10 command frozen", {32'd0, cmd_rd}, {32'd0, c});
    end
    rd = {c ^ 32'h3C3C_A5A5, ~ea};
    mem_ack = 1'b1; mem_rdata = rd;
    @(negedge clk);
    mem_ack = 1'b0; mem_rdata = '0;
    chk("R9 released after ack", {62'd0, busy, mem_req}, 64'd0);
    if (c[1]) chk("R3 R10 words unchanged", {dat1_rd, dat0_rd}, {w1, w0});
    else      chk("R4 read data", {dat1_rd, dat0_rd}, rd);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        fails++;
        $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
      end
    end
  end

  initial begin
    logic [31:0] lf;
    repeat (3) @(negedge clk);
    chk("R1 reset words", {dat1_rd, dat0_rd}, 64'd0);
    chk("R1 reset command", {32'd0, cmd_rd}, 64'd0);
    chk("R1 reset status", {59'd0, busy, mem_req, err_undef, err_tag, mem_we}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    run_cmd(32'h0000_0001, 0);
    run_cmd(32'd0, 0);
    for (int b = 0; b < 32; b++) begin
      run_cmd(32'd1 << b, 1);
      set_data(32'h1111_0000 + b, 32'h2222_0000 + b);
      run_cmd((32'd1 << b) | 32'h4, b % 3);
      run_cmd((32'd1 << b) | 32'h6, 1);
    end
    lf = 32'hACE1_1357;
    for (int n = 0; n < 60; n++) begin
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      if (n == 30) sram_base = 32'h0010_0000;
      set_data(lf, ~lf);
      run_cmd((lf & ~32'hFA7CB801) | 32'h4, n % 4);
      if (n % 10 == 0) run_cmd(32'd0, 0);
      if (n % 7 == 0) run_cmd(lf | 32'h0000_0801, 0);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule